// File: doc/BRIEF.md
# Thread Context Status and Binding Registers

This block keeps the status word and the binding word for a parameterised number of hardware thread contexts (eight by default). Software reaches one context at a time: it writes through a thread-select index, and it reads a registered copy of the selected context's two words. Pipeline events arrive as one strobe per thread: retirement, fork dispatch, yield, halt and bus error. From these events the block sets, clears or leaves each hardware-owned bit.

A fork copies the privilege mode and the address-space ID from a parent thread, which is named by a single index shared by every fork in that cycle. Coprocessor enables, the media enable and the interrupt-exempt bit stay as they were. The processor-binding field changes only while a global configuration enable is high. When a hardware event and a software write touch the same bit in the same cycle, the event wins.

Top module: `ctx_status_regs`

## Requirements
- R1: After synchronous reset, thread 0 reads status with only the activated bit (bit 13) set. Every other thread reads status zero apart from its run-state input. Every binding field is zero.
- R2: The dirty bit (status bit 20) is 1 one cycle after a fork strobe for that thread, or after a retire strobe for that thread while all three mode flags are low.
- R3: A retire strobe leaves the dirty bit unchanged while any of the exception-level, error-level or debug mode flags is high.
- R4: A fork strobe sets the activated bit (13) and a yield strobe clears it. When both come in the same cycle, the bit is set.
- R5: A halt strobe loads the delay-slot bit (21) from the thread's in-delay-slot input. A software restart-address write to the selected thread clears the bit. A halt in the same cycle takes precedence over that write.
- R6: A bus-error strobe sets the thread's bus-error bit (binding bit 17). Several threads can be set in one cycle. Software can write the bit to either value.
- R7: The processor-binding field (binding bits 3:0) takes the written value only while the configuration enable is high. Otherwise it keeps its value.
- R8: The binding word carries the thread index in bits 28:21. Bits 31:29, 20:18 and 16:4 read zero.
- R9: A fork copies privilege mode (12:11) and address-space ID (7:0) from the thread named by the fork-parent index. It leaves coprocessor enables (31:28), media enable (27) and interrupt-exempt (10) unchanged.
- R10: A status write stores bits 31:27, 20, 15, 13, 12:11, 10 and 7:0. Bits 24:23 show the thread's run-state input. Bit 21 cannot be written. A read shows the selected thread one cycle after the select is applied.
- R11: A hardware set event on a bit overrides a software write of 0 to the same bit in the same cycle.
- R12: Bits 26:25, 22, 19:16, 14 and 9:8 of the status word are ignored on write and read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_sel | input | IDX_W | Thread chosen for software read and write |
| sw_wr_status | input | 1 | Write sw_wdata to the selected status word |
| sw_wr_bind | input | 1 | Write sw_wdata to the selected binding word |
| sw_wr_restart | input | 1 | Software wrote the selected thread's restart address |
| sw_wdata | input | 32 | Software write data |
| cfg_bind_en | input | 1 | Global enable for binding-field writes |
| mode_exl | input | 1 | Exception level active for retiring instructions |
| mode_erl | input | 1 | Error level active for retiring instructions |
| mode_dbg | input | 1 | Debug mode active for retiring instructions |
| ev_retire | input | NUM_THR | Per-thread instruction retirement |
| ev_fork | input | NUM_THR | Per-thread successful fork dispatch |
| fork_parent | input | IDX_W | Forking thread whose mode and ID are copied |
| ev_yield | input | NUM_THR | Per-thread deallocation by yield |
| ev_halt | input | NUM_THR | Per-thread halt |
| halt_in_slot | input | NUM_THR | Next instruction lies in a branch delay slot |
| ev_buserr | input | NUM_THR | Per-thread bus error attribution |
| thr_run_state | input | 2*NUM_THR | Per-thread run-state code |
| rd_status | output | 32 | Registered status word of the selected thread |
| rd_bind | output | 32 | Registered binding word of the selected thread |

## Verification
Retirement is swept over every thread crossed with all eight combinations of the three mode flags. This separates the single enabling combination from the seven inhibiting ones and shows that the other threads stay untouched. Fork is tried with a different parent for each thread, and each parent holds distinct mode and ID values, so copying from the wrong parent or copying the wrong fields gives a wrong readback. Collision patterns show which side wins when the same bit is hit twice in one cycle: fork with yield, halt with restart write, and hardware event with software write. Binding writes are repeated with the enable low and high to show when the field is locked.

// File: rtl/ctx_stat_pkg.sv
package ctx_stat_pkg;
  localparam int unsigned VPE_W  = 4;
  localparam int unsigned ASID_W = 8;
  localparam int unsigned CU_W   = 4;

  typedef struct packed {
    logic [CU_W-1:0]   cu;
    logic              mx;
    logic              ds;
    logic              dt;
    logic              da;
    logic              act;
    logic [1:0]        ksu;
    logic              ixmt;
    logic [ASID_W-1:0] asid;
    logic              tbe;
    logic [VPE_W-1:0]  vpe;
  } thr_state_t;

  function automatic logic [31:0] pack_status(thr_state_t s, logic [1:0] run);
    logic [31:0] w;
    w        = '0;
    w[31:28] = s.cu;
    w[27]    = s.mx;
    w[24:23] = run;
    w[21]    = s.ds;
    w[20]    = s.dt;
    w[15]    = s.da;
    w[13]    = s.act;
    w[12:11] = s.ksu;
    w[10]    = s.ixmt;
    w[7:0]   = s.asid;
    return w;
  endfunction

  function automatic logic [31:0] pack_bind(thr_state_t s, logic [7:0] idx);
    logic [31:0] w;
    w        = '0;
    w[28:21] = idx;
    w[17]    = s.tbe;
    w[3:0]   = s.vpe;
    return w;
  endfunction
endpackage

// File: rtl/ctx_thread_slot.sv
module ctx_thread_slot
  import ctx_stat_pkg::*;
#(
  parameter int unsigned THR_ID = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_status,
  input  logic              we_bind,
  input  logic              we_restart,
  input  logic [31:0]       wdata,
  input  logic              bind_en,
  input  logic              retire_ok,
  input  logic              fork_in,
  input  logic [1:0]        fork_ksu,
  input  logic [ASID_W-1:0] fork_asid,
  input  logic              yield_in,
  input  logic              halt_in,
  input  logic              halt_ds,
  input  logic              buserr_in,
  output thr_state_t        st
);
  thr_state_t nx;

  // Software first, hardware events afterwards so that they win.
  always_comb begin
    nx = st;
    if (we_status) begin
      nx.cu   = wdata[31:28];
      nx.mx   = wdata[27];
      nx.dt   = wdata[20];
      nx.da   = wdata[15];
      nx.act  = wdata[13];
      nx.ksu  = wdata[12:11];
      nx.ixmt = wdata[10];
      nx.asid = wdata[7:0];
    end
    if (we_bind) begin
      nx.tbe = wdata[17];
      if (bind_en) nx.vpe = wdata[3:0];
    end
    if (we_restart) nx.ds = 1'b0;
    if (yield_in)   nx.act = 1'b0;
    if (halt_in)    nx.ds = halt_ds;
    if (retire_ok || fork_in) nx.dt = 1'b1;
    if (fork_in) begin
      nx.act  = 1'b1;
      nx.ksu  = fork_ksu;
      nx.asid = fork_asid;
    end
    if (buserr_in) nx.tbe = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= '0;
      st.act <= (THR_ID == 0);
    end else begin
      st <= nx;
    end
  end
endmodule

// File: rtl/ctx_read_port.sv
module ctx_read_port
  import ctx_stat_pkg::*;
#(
  parameter int unsigned NUM_THR = 8,
  parameter int unsigned IDX_W   = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [IDX_W-1:0]           sel,
  input  thr_state_t [NUM_THR-1:0]   st_vec,
  input  logic [2*NUM_THR-1:0]       run_vec,
  output logic [31:0]                rd_status,
  output logic [31:0]                rd_bind
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_status <= '0;
      rd_bind   <= '0;
    end else begin
      rd_status <= pack_status(st_vec[sel], run_vec[2*sel +: 2]);
      rd_bind   <= pack_bind(st_vec[sel], 8'(sel));
    end
  end
endmodule

// File: rtl/ctx_status_regs.sv
module ctx_status_regs
  import ctx_stat_pkg::*;
#(
  parameter int unsigned NUM_THR = 8,
  parameter int unsigned IDX_W   = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [IDX_W-1:0]     sw_sel,
  input  logic                 sw_wr_status,
  input  logic                 sw_wr_bind,
  input  logic                 sw_wr_restart,
  input  logic [31:0]          sw_wdata,
  input  logic                 cfg_bind_en,
  input  logic                 mode_exl,
  input  logic                 mode_erl,
  input  logic                 mode_dbg,
  input  logic [NUM_THR-1:0]   ev_retire,
  input  logic [NUM_THR-1:0]   ev_fork,
  input  logic [IDX_W-1:0]     fork_parent,
  input  logic [NUM_THR-1:0]   ev_yield,
  input  logic [NUM_THR-1:0]   ev_halt,
  input  logic [NUM_THR-1:0]   halt_in_slot,
  input  logic [NUM_THR-1:0]   ev_buserr,
  input  logic [2*NUM_THR-1:0] thr_run_state,
  output logic [31:0]          rd_status,
  output logic [31:0]          rd_bind
);
  thr_state_t [NUM_THR-1:0] thr_st;
  logic                     retire_gate;
  logic [1:0]               par_ksu;
  logic [ASID_W-1:0]        par_asid;

  assign retire_gate = ~(mode_exl | mode_erl | mode_dbg);
  assign par_ksu     = thr_st[fork_parent].ksu;
  assign par_asid    = thr_st[fork_parent].asid;

  for (genvar g = 0; g < NUM_THR; g++) begin : g_slot
    logic hit;
    assign hit = (sw_sel == IDX_W'(g));
    ctx_thread_slot #(.THR_ID(g)) u_slot (
      .clk        (clk),
      .rst        (rst),
      .we_status  (sw_wr_status & hit),
      .we_bind    (sw_wr_bind & hit),
      .we_restart (sw_wr_restart & hit),
      .wdata      (sw_wdata),
      .bind_en    (cfg_bind_en),
      .retire_ok  (ev_retire[g] & retire_gate),
      .fork_in    (ev_fork[g]),
      .fork_ksu   (par_ksu),
      .fork_asid  (par_asid),
      .yield_in   (ev_yield[g]),
      .halt_in    (ev_halt[g]),
      .halt_ds    (halt_in_slot[g]),
      .buserr_in  (ev_buserr[g]),
      .st         (thr_st[g])
    );
  end

  ctx_read_port #(.NUM_THR(NUM_THR), .IDX_W(IDX_W)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .sel       (sw_sel),
    .st_vec    (thr_st),
    .run_vec   (thr_run_state),
    .rd_status (rd_status),
    .rd_bind   (rd_bind)
  );
endmodule

// File: rtl/ctx_status_chk.sv
module ctx_status_chk
  import ctx_stat_pkg::*;
#(
  parameter int unsigned NUM_THR = 8,
  parameter int unsigned IDX_W   = 3
) (
  input logic                     clk,
  input logic                     rst,
  input logic [IDX_W-1:0]         sw_sel,
  input logic                     sw_wr_status,
  input logic                     sw_wr_restart,
  input logic                     cfg_bind_en,
  input logic                     mode_exl,
  input logic                     mode_erl,
  input logic                     mode_dbg,
  input logic [NUM_THR-1:0]       ev_retire,
  input logic [NUM_THR-1:0]       ev_fork,
  input logic [NUM_THR-1:0]       ev_yield,
  input logic [NUM_THR-1:0]       ev_halt,
  input logic [NUM_THR-1:0]       halt_in_slot,
  input logic [NUM_THR-1:0]       ev_buserr,
  input thr_state_t [NUM_THR-1:0] thr_st,
  input logic [31:0]              rd_status,
  input logic [31:0]              rd_bind
);
  logic inhibit;
  assign inhibit = mode_exl | mode_erl | mode_dbg;

  for (genvar i = 0; i < NUM_THR; i++) begin : g_thr
    logic own;
    assign own = (sw_sel == IDX_W'(i));

    AST_DIRTY_SET: assert property (@(posedge clk) disable iff (rst)
      (ev_fork[i] || (ev_retire[i] && !inhibit)) |=> thr_st[i].dt); // R2
    AST_DIRTY_INHIBIT: assert property (@(posedge clk) disable iff (rst)
      (ev_retire[i] && inhibit && !ev_fork[i] && !(sw_wr_status && own))
        |=> $stable(thr_st[i].dt)); // R3
    AST_ACT_FORK: assert property (@(posedge clk) disable iff (rst)
      ev_fork[i] |=> thr_st[i].act); // R4
    AST_ACT_YIELD: assert property (@(posedge clk) disable iff (rst)
      (ev_yield[i] && !ev_fork[i]) |=> !thr_st[i].act); // R4
    AST_DS_HALT: assert property (@(posedge clk) disable iff (rst)
      ev_halt[i] |=> (thr_st[i].ds == $past(halt_in_slot[i]))); // R5
    AST_DS_RESTART: assert property (@(posedge clk) disable iff (rst)
      (sw_wr_restart && own && !ev_halt[i]) |=> !thr_st[i].ds); // R5
    AST_BUSERR_SET: assert property (@(posedge clk) disable iff (rst)
      ev_buserr[i] |=> thr_st[i].tbe); // R6
    AST_VPE_LOCK: assert property (@(posedge clk) disable iff (rst)
      !cfg_bind_en |=> $stable(thr_st[i].vpe)); // R7
  end

  AST_BIND_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_bind[31:29] == 3'b0) && (rd_bind[20:18] == 3'b0)); // R8
  AST_STATUS_RSVD: assert property (@(posedge clk) disable iff (rst)
    (rd_status[26:25] == 2'b0) && !rd_status[22] && (rd_status[19:16] == 4'b0)
      && !rd_status[14] && (rd_status[9:8] == 2'b0)); // R12
  AST_RESET_ACT: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (thr_st[0].act && (thr_st[0].vpe == '0))); // R1
endmodule

bind ctx_status_regs ctx_status_chk #(.NUM_THR(NUM_THR), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/test_ctx_status_regs.sv
module test_ctx_status_regs;
  localparam int N = 8;
  localparam int IW = 3;
  localparam logic [31:0] WMASK = 32'hF810_BCFF;
  localparam logic [31:0] B_DT = 32'h0010_0000;
  localparam logic [31:0] B_ACT = 32'h0000_2000;
  localparam logic [31:0] B_KA = 32'h0000_18FF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [IW-1:0] sw_sel = '0;
  logic sw_wr_status = 0, sw_wr_bind = 0, sw_wr_restart = 0;
  logic [31:0] sw_wdata = '0;
  logic cfg_bind_en = 0, mode_exl = 0, mode_erl = 0, mode_dbg = 0;
  logic [N-1:0] ev_retire = '0, ev_fork = '0, ev_yield = '0, ev_halt = '0;
  logic [N-1:0] halt_in_slot = '0, ev_buserr = '0;
  logic [IW-1:0] fork_parent = '0;
  logic [2*N-1:0] thr_run_state;
  logic [31:0] rd_status, rd_bind;

  always #10 clk = ~clk;

  always_comb
    for (int k = 0; k < N; k++) thr_run_state[2*k +: 2] = 2'(k % 4);

  ctx_status_regs #(.NUM_THR(N)) i_ctx_status_regs (.*);

  int total = 0, bad = 0;
  logic [31:0] e_w [N];
  logic e_ds [N], e_tbe [N];
  logic [3:0] e_vpe [N];

  task automatic cmp(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(int i, string req);
    logic [31:0] es, eb;
    sw_sel = IW'(i);
    tick();
    es = e_w[i] | (32'(e_ds[i]) << 21) | (32'(i % 4) << 23);
    eb = (32'(i) << 21) | (32'(e_tbe[i]) << 17) | 32'(e_vpe[i]);
    cmp({req, " status"}, rd_status, es);
    cmp({req, " bind"}, rd_bind, eb);
  endtask

  task automatic wr_stat(int i, logic [31:0] v);
    sw_sel = IW'(i); sw_wdata = v; sw_wr_status = 1;
    tick();
    sw_wr_status = 0;
    e_w[i] = v & WMASK;
  endtask

  task automatic wr_bind(int i, logic [31:0] v);
    sw_sel = IW'(i); sw_wdata = v; sw_wr_bind = 1;
    tick();
    sw_wr_bind = 0;
    e_tbe[i] = v[17];
    if (cfg_bind_en) e_vpe[i] = v[3:0];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      e_w[i] = (i == 0) ? B_ACT : 32'h0;
      e_ds[i] = 0; e_tbe[i] = 0; e_vpe[i] = 0;
    end
    repeat (3) tick();
    rst = 0;
    // R1 reset values
    for (int i = 0; i < N; i++) chk(i, "R1");
    // R10 and R12: write all ones then zero
    for (int i = 0; i < N; i++) begin
      wr_stat(i, 32'hFFFF_FFFF); chk(i, "R10_R12");
      wr_stat(i, 32'h0);         chk(i, "R10");
    end
    // R2/R3 retire crossed with every mode combination
    for (int i = 0; i < N; i++)
      for (int m = 0; m < 8; m++) begin
        {mode_exl, mode_erl, mode_dbg} = 3'(m);
        ev_retire[i] = 1;
        tick();
        ev_retire = '0; {mode_exl, mode_erl, mode_dbg} = 3'b0;
        if (m == 0) e_w[i] |= B_DT;
        chk(i, (m == 0) ? "R2" : "R3");
        wr_stat(i, 32'h0);
      end
    // R9 fork copies from parent, R2 dirty on fork
    for (int t = 0; t < N; t++) begin
      int p;
      p = (t + 3) % N;
      wr_stat(p, (32'(p % 4) << 11) | 32'(8'h40 + p) | 32'h0000_8000);
      wr_stat(t, 32'hA800_0411);
      fork_parent = IW'(p); ev_fork[t] = 1;
      tick();
      ev_fork = '0;
      e_w[t] = (e_w[t] & ~B_KA) | (e_w[p] & B_KA) | B_ACT | B_DT;
      chk(t, "R9_R2");
      chk(p, "R9 parent");
    end
    // R4 yield clears, fork+yield sets
    for (int t = 0; t < N; t++) begin
      ev_yield[t] = 1; tick(); ev_yield = '0;
      e_w[t] &= ~B_ACT;
      chk(t, "R4 yield");
      fork_parent = IW'(t); ev_yield[t] = 1; ev_fork[t] = 1; tick();
      ev_yield = '0; ev_fork = '0;
      e_w[t] |= B_ACT | B_DT;
      chk(t, "R4 collide");
    end
    // R5 delay slot
    for (int t = 0; t < N; t++) begin
      ev_halt[t] = 1; halt_in_slot[t] = 1; tick(); ev_halt = '0; halt_in_slot = '0;
      e_ds[t] = 1; chk(t, "R5 set");
      ev_halt[t] = 1; tick(); ev_halt = '0;
      e_ds[t] = 0; chk(t, "R5 clr");
      ev_halt[t] = 1; halt_in_slot[t] = 1; tick(); ev_halt = '0; halt_in_slot = '0;
      e_ds[t] = 1;
      sw_sel = IW'((t + 1) % N); sw_wr_restart = 1; tick(); sw_wr_restart = 0;
      chk(t, "R5 other");
      sw_sel = IW'(t); sw_wr_restart = 1; ev_halt[t] = 1; halt_in_slot[t] = 1;
      tick(); sw_wr_restart = 0; ev_halt = '0; halt_in_slot = '0;
      chk(t, "R5 halt wins");
      sw_sel = IW'(t); sw_wr_restart = 1; tick(); sw_wr_restart = 0;
      e_ds[t] = 0; chk(t, "R5 restart");
    end
    // R6 bus error on several threads
    ev_buserr = 8'hA5; tick(); ev_buserr = '0;
    for (int t = 0; t < N; t++) begin
      e_tbe[t] = (t == 0 || t == 2 || t == 5 || t == 7);
      chk(t, "R6");
    end
    for (int t = 0; t < N; t++) begin
      wr_bind(t, 32'h0); chk(t, "R6 clear");
    end
    // R7 and R8 binding field lock
    for (int t = 0; t < N; t++) begin
      cfg_bind_en = 0; wr_bind(t, 32'hFFFF_FFFF); chk(t, "R7_R8 locked");
      cfg_bind_en = 1; wr_bind(t, 32'(4'(t + 5))); chk(t, "R7 open");
      cfg_bind_en = 0; wr_bind(t, 32'h0); chk(t, "R7 hold");
    end
    // R11 hardware over software
    for (int t = 0; t < N; t++) begin
      sw_sel = IW'(t); sw_wdata = 32'h0; sw_wr_status = 1; sw_wr_bind = 1;
      ev_retire[t] = 1; ev_buserr[t] = 1;
      tick();
      sw_wr_status = 0; sw_wr_bind = 0; ev_retire = '0; ev_buserr = '0;
      e_w[t] = B_DT; e_tbe[t] = 1;
      chk(t, "R11");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule